// File: doc/BRIEF.md
# Dual-Channel Double-Data-Rate Sample Deserializer

This block sits behind the receivers of a dual 14-bit converter whose output bus runs at double data rate. Each channel drives its own group of lanes, and each lane carries two adjacent bits of a sample in every period of the forwarded clock. The even bit arrives in the first half of the period and the odd bit in the second half. One more lane carries both channels' overflow flags in the same period: channel B's flag first, then channel A's.

The block samples every lane on both edges of the forwarded clock. It keeps the first-half bits in a holding register. On the edge that closes the period it joins them with the second-half bits into one full word per channel, plus one overflow flag per channel. Those results are registered, and a valid strobe rises beside them. A parameter swaps which edge opens the period, so a forwarded clock with inverted polarity can be used without logic outside the block. Any pipeline latency inside the converter comes before the bus, so the block adds only its own single register stage.

Top module: `ddr_pair_capture`

## Requirements
- R1: For lane k of channel A (k from 0 to LANES-1), the level in the first half of a period becomes output bit 2k and the level in the second half becomes bit 2k+1.
- R2: Channel B uses its own lane group with the same bit mapping as R1, and both channels' words for one period appear on the outputs on the same edge.
- R3: On the shared overflow lane, the first-half level becomes the channel B flag and the second-half level becomes the channel A flag.
- R4: The bits of one period appear on the outputs just after the edge that closes that period, and they stay there for exactly one period.
- R5: After reset is released, the outputs stay at zero and valid stays low through the first two period-closing edges. Valid first rises at the third of those edges.
- R6: Reset is active low and asynchronous. While it is low, every word and flag output is zero and valid is low, and this takes effect without waiting for a clock edge.
- R7: With INVERT_CLK=0, a period opens on the rising edge of the forwarded clock and closes on the next rising edge. With INVERT_CLK=1, a period opens and closes on falling edges, and the outputs then match what INVERT_CLK=0 gives on the complemented clock.
- R8: Once valid has risen, it stays high on every following period, marking one new word pair per period until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_clk | input | 1 | Forwarded clock that accompanies the data lanes |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_a | input | LANES | Channel A data lanes, two bits per lane per period |
| lane_b | input | LANES | Channel B data lanes, two bits per lane per period |
| lane_ovf | input | 1 | Shared overflow lane: B flag first, then A flag |
| word_a | output | 2*LANES | Rebuilt channel A sample |
| word_b | output | 2*LANES | Rebuilt channel B sample |
| flag_a | output | 1 | Channel A overflow flag |
| flag_b | output | 1 | Channel B overflow flag |
| word_vld | output | 1 | High when word_a, word_b and the flags hold a rebuilt period |

## Verification
The assertions check the following on every closing edge:
- while valid is high, the odd bits of both words and the channel A flag equal the lane levels at the previous closing edge;
- outputs are zero whenever valid is low;
- reset clears everything;
- valid never drops once it has risen.

Three behaviours cannot be seen from closing-edge samples alone, so only the bench scenarios show them:
- the even bits and the channel B flag, which are taken on the opposite edge;
- the exact count of warm-up periods;
- the match between the two clock polarities.

The bench covers these with walking-one and walking-zero words followed by an arithmetic sweep, with a six-period transmitter pipeline in front of the block.

// File: rtl/ddr_pair_capture.sv
`timescale 1ns/1ps
module ddr_pair_capture #(
  parameter int LANES = 7,
  parameter bit INVERT_CLK = 1'b0,
  localparam int W = 2 * LANES
) (
  input  logic             fwd_clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_a,
  input  logic [LANES-1:0] lane_b,
  input  logic             lane_ovf,
  output logic [W-1:0]     word_a,
  output logic [W-1:0]     word_b,
  output logic             flag_a,
  output logic             flag_b,
  output logic             word_vld
);

  logic rx_clk;
  assign rx_clk = fwd_clk ^ INVERT_CLK;

  logic [LANES-1:0] hold_a, hold_b;
  logic             hold_ovf;
  logic [1:0]       warm;
  logic [W-1:0]     asm_a, asm_b;
  logic             ready;

  always_ff @(negedge rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a   <= '0;
      hold_b   <= '0;
      hold_ovf <= 1'b0;
    end else begin
      hold_a   <= lane_a;
      hold_b   <= lane_b;
      hold_ovf <= lane_ovf;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_pair
    assign asm_a[2*k]   = hold_a[k];
    assign asm_a[2*k+1] = lane_a[k];
    assign asm_b[2*k]   = hold_b[k];
    assign asm_b[2*k+1] = lane_b[k];
  end

  assign ready = (warm == 2'd2);

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n)      warm <= 2'd0;
    else if (!ready) warm <= warm + 2'd1;
  end

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n || !ready) begin
      word_a   <= '0;
      word_b   <= '0;
      flag_a   <= 1'b0;
      flag_b   <= 1'b0;
      word_vld <= 1'b0;
    end else begin
      word_a   <= asm_a;
      word_b   <= asm_b;
      flag_a   <= lane_ovf;
      flag_b   <= hold_ovf;
      word_vld <= 1'b1;
    end
  end

endmodule

module ddr_pair_capture_chk #(
  parameter int LANES = 7,
  parameter bit INVERT_CLK = 1'b0
) (
  input logic               fwd_clk,
  input logic               rst_n,
  input logic [LANES-1:0]   lane_a,
  input logic [LANES-1:0]   lane_b,
  input logic               lane_ovf,
  input logic [2*LANES-1:0] word_a,
  input logic [2*LANES-1:0] word_b,
  input logic               flag_a,
  input logic               flag_b,
  input logic               word_vld
);

  logic rx;
  assign rx = fwd_clk ^ INVERT_CLK;

  function automatic logic [LANES-1:0] odd_of(input logic [2*LANES-1:0] w);
    logic [LANES-1:0] r;
    for (int k = 0; k < LANES; k++) r[k] = w[2*k+1];
    return r;
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge rx) !rst_n |-> (!word_vld && word_a == '0 && word_b == '0 && !flag_a && !flag_b)); // R6
  AST_IDLE_ZERO: assert property (@(posedge rx) disable iff (!rst_n) !word_vld |-> (word_a == '0 && word_b == '0 && !flag_a && !flag_b)); // R5
  AST_ODD_A: assert property (@(posedge rx) disable iff (!rst_n) word_vld |-> odd_of(word_a) == $past(lane_a)); // R1
  AST_ODD_B: assert property (@(posedge rx) disable iff (!rst_n) word_vld |-> odd_of(word_b) == $past(lane_b)); // R2
  AST_FLAG_A: assert property (@(posedge rx) disable iff (!rst_n) word_vld |-> flag_a == $past(lane_ovf)); // R3
  AST_VLD_HOLD: assert property (@(posedge rx) disable iff (!rst_n) word_vld |=> word_vld); // R8

endmodule

bind ddr_pair_capture ddr_pair_capture_chk #(.LANES(LANES), .INVERT_CLK(INVERT_CLK)) u_chk (
  .fwd_clk(fwd_clk), .rst_n(rst_n), .lane_a(lane_a), .lane_b(lane_b),
  .lane_ovf(lane_ovf), .word_a(word_a), .word_b(word_b),
  .flag_a(flag_a), .flag_b(flag_b), .word_vld(word_vld)
);

// File: tb/sim_ddr_pair_capture.sv
`timescale 1ns/1ps
module sim_ddr_pair_capture;
  localparam int L = 7;
  localparam int W = 2 * L;
  localparam int PIPE = 6;

  logic clk = 1'b0, rst_n = 1'b0, lo = 1'b0;
  logic [L-1:0] la = '0, lb = '0;
  logic [W-1:0] wa0, wb0, wa1, wb1;
  logic fa0, fb0, fa1, fb1, v0, v1;
  int checks = 0, errors = 0, gp = 0;

  always #2.5 clk = ~clk;

  ddr_pair_capture #(.LANES(L), .INVERT_CLK(1'b0)) u0 (
    .fwd_clk(clk), .rst_n(rst_n), .lane_a(la), .lane_b(lb), .lane_ovf(lo),
    .word_a(wa0), .word_b(wb0), .flag_a(fa0), .flag_b(fb0), .word_vld(v0));

  ddr_pair_capture #(.LANES(L), .INVERT_CLK(1'b1)) u1 (
    .fwd_clk(~clk), .rst_n(rst_n), .lane_a(la), .lane_b(lb), .lane_ovf(lo),
    .word_a(wa1), .word_b(wb1), .flag_a(fa1), .flag_b(fb1), .word_vld(v1));

  function automatic logic [W-1:0] samp_a(int n);
    if (n < W)        return W'(1) << n;
    else if (n < 2*W) return ~(W'(1) << (n - W));
    else              return W'(n * 1237 + 5);
  endfunction
  function automatic logic [W-1:0] samp_b(int n);
    if (n < W)        return ~(W'(1) << n);
    else if (n < 2*W) return W'(1) << (n - W);
    else              return W'((n * 4093) ^ 677);
  endfunction
  function automatic logic tx_ofa(int q); return (q >= PIPE) && ((q - PIPE) % 3 == 0); endfunction
  function automatic logic tx_ofb(int q); return (q >= PIPE) && ((q - PIPE) % 5 == 1); endfunction
  function automatic logic [W-1:0] tx_a(int q); return (q >= PIPE) ? samp_a(q - PIPE) : '0; endfunction
  function automatic logic [W-1:0] tx_b(int q); return (q >= PIPE) ? samp_b(q - PIPE) : '0; endfunction
  function automatic logic [L-1:0] evn(logic [W-1:0] w);
    logic [L-1:0] r;
    for (int k = 0; k < L; k++) r[k] = w[2*k];
    return r;
  endfunction
  function automatic logic [L-1:0] odd(logic [W-1:0] w);
    logic [L-1:0] r;
    for (int k = 0; k < L; k++) r[k] = w[2*k+1];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_zero(string tag);
    chk({tag, " word_a u0"}, 32'(wa0), 0);
    chk({tag, " word_b u0"}, 32'(wb0), 0);
    chk({tag, " flags u0"}, {30'd0, fa0, fb0}, 0);
    chk({tag, " valid u0"}, 32'(v0), 0);
    chk({tag, " word_a u1"}, 32'(wa1), 0);
    chk({tag, " word_b u1"}, 32'(wb1), 0);
    chk({tag, " flags u1"}, {30'd0, fa1, fb1}, 0);
    chk({tag, " valid u1"}, 32'(v1), 0);
  endtask

  task automatic run(int nper);
    for (int p = 0; p < nper; p++) begin
      @(posedge clk);
      #1;
      if (p + 1 < 3) chk_zero("R5 warm-up");
      else begin
        chk("R4 R8 valid u0", 32'(v0), 1);
        chk("R1 R4 word_a u0", 32'(wa0), 32'(tx_a(gp - 1)));
        chk("R2 word_b u0", 32'(wb0), 32'(tx_b(gp - 1)));
        chk("R3 flag_a u0", 32'(fa0), 32'(tx_ofa(gp - 1)));
        chk("R3 flag_b u0", 32'(fb0), 32'(tx_ofb(gp - 1)));
        chk("R7 valid u1", 32'(v1), 1);
        chk("R7 word_a u1", 32'(wa1), 32'(tx_a(gp - 1)));
        chk("R7 word_b u1", 32'(wb1), 32'(tx_b(gp - 1)));
        chk("R7 flags u1", {30'd0, fa1, fb1}, {30'd0, tx_ofa(gp - 1), tx_ofb(gp - 1)});
      end
      la = evn(tx_a(gp));
      lb = evn(tx_b(gp));
      lo = tx_ofb(gp);
      @(negedge clk);
      #1;
      la = odd(tx_a(gp));
      lb = odd(tx_b(gp));
      lo = tx_ofa(gp);
      gp++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    la = 7'h55; lb = 7'h2a; lo = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk_zero("R6 reset held");
    @(negedge clk);
    #1 rst_n = 1'b1;
    run(2 * W + 40);
    #0.5 rst_n = 1'b0;
    #0.5 chk_zero("R6 async reset mid-run");
    @(negedge clk);
    #1 rst_n = 1'b1;
    run(30);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule